// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block chooses the micro-address of the next control-store word in a microcoded multicycle processor. It holds a 4-bit micro-address register. Each cycle it loads one of four values into that register: zero (the fetch entry), a target from the decode table, a target from the memory-split table, or the present address plus one. The 2-bit sequencing field of the current microinstruction chooses the source.

Both tables are indexed by the 6-bit opcode held in the instruction register. The decode table sends each supported instruction class to the first state of its routine, and it sends loads and stores to a single shared address-calculation state. From that shared state, the memory-split table separates loads from stores. Any opcode that neither table recognises is sent to the illegal-instruction exception state, 12, so the sequencer never enters a state that has no microcode.

The control store and the datapath are outside this block. The opcode must stay stable while a table is selected. Only the micro-address register is clocked; all next-address selection is combinational.

Top module: `micro_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `uAddr` becomes 0 at that edge. Reset is synchronous and active high.
- R2: With `seqSel` = 2'b00, the next `uAddr` is 0.
- R3: With `seqSel` = 2'b11, the next `uAddr` is the current `uAddr` plus 1, modulo 16, so 15 is followed by 0.
- R4: With `seqSel` = 2'b01, these opcodes give these next `uAddr` values: 6'b000000 gives 6, 6'b000010 gives 9, 6'b000100 gives 8, and 6'b001011 gives 10.
- R5: With `seqSel` = 2'b01, opcodes 6'b100011 and 6'b101011 both give next `uAddr` 2.
- R6: With `seqSel` = 2'b01, every opcode not listed in R4 or R5 gives next `uAddr` 12.
- R7: With `seqSel` = 2'b10, opcode 6'b100011 gives next `uAddr` 3, and opcode 6'b101011 gives next `uAddr` 5.
- R8: With `seqSel` = 2'b10, every opcode other than the two in R7 gives next `uAddr` 12.
- R9: With `seqSel` = 2'b00 or 2'b11, the opcode has no effect on the next `uAddr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the micro-address register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to micro-address 0 |
| opcode | input | 6 | Opcode field of the instruction register |
| seqSel | input | 2 | Sequencing field of the current microinstruction |
| uAddr | output | 4 | Current micro-address |

## Verification
The bench applies all 64 opcodes under each of the four `seqSel` codes, starting from every one of the 16 micro-addresses. Starting from every address shows that the increment path wraps from 15 to 0. It also shows that the zero path and both table paths ignore the starting state. Running all opcodes under the zero and increment codes shows that the opcode has no effect there. Running all opcodes under the two table codes separates each listed opcode from its neighbours and confirms that every unlisted code falls to state 12.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int OP_W = 6;
  localparam int UA_W = 4;

  // Sequencing codes; the encoding is fixed by the microinstruction format.
  localparam logic [1:0] SEQ_FETCH = 2'b00;
  localparam logic [1:0] SEQ_MAIN  = 2'b01;
  localparam logic [1:0] SEQ_MEM   = 2'b10;
  localparam logic [1:0] SEQ_NEXT  = 2'b11;

  // Opcodes recognised by the tables.
  localparam logic [OP_W-1:0] OPC_REG   = 6'b000000;
  localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;
  localparam logic [OP_W-1:0] OPC_BREQ  = 6'b000100;
  localparam logic [OP_W-1:0] OPC_ORIMM = 6'b001011;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;

  // Entry states of the microcode routines.
  localparam int ST_ADDRCALC = 2;
  localparam int ST_LOADMEM  = 3;
  localparam int ST_STOREMEM = 5;
  localparam int ST_REGEXEC  = 6;
  localparam int ST_BRANCH   = 8;
  localparam int ST_JUMP     = 9;
  localparam int ST_ORIEXEC  = 10;
  localparam int ST_ILLEGAL  = 12;

  // One-hot source strobes from the control half to the address datapath.
  typedef struct packed {
    logic takeNext;
    logic takeMem;
    logic takeMain;
    logic takeZero;
  } seqStrobe_t;

endpackage

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int AW = UA_W
) (
  input  logic [OP_W-1:0] opcode,
  output logic [AW-1:0]   mainTgt,
  output logic [AW-1:0]   memTgt
);

  // Decode table: one entry per supported class, loads and stores share one entry.
  always_comb begin
    unique case (opcode)
      OPC_REG:   mainTgt = AW'(ST_REGEXEC);
      OPC_JUMP:  mainTgt = AW'(ST_JUMP);
      OPC_BREQ:  mainTgt = AW'(ST_BRANCH);
      OPC_ORIMM: mainTgt = AW'(ST_ORIEXEC);
      OPC_LOAD,
      OPC_STORE: mainTgt = AW'(ST_ADDRCALC);
      default:   mainTgt = AW'(ST_ILLEGAL);
    endcase
  end

  // Memory-split table: separates loads from stores; anything else traps.
  always_comb begin
    unique case (opcode)
      OPC_LOAD:  memTgt = AW'(ST_LOADMEM);
      OPC_STORE: memTgt = AW'(ST_STOREMEM);
      default:   memTgt = AW'(ST_ILLEGAL);
    endcase
  end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic [1:0]  seqSel,
  output seqStrobe_t  strobe
);

  always_comb begin
    strobe = '0;
    case (seqSel)
      SEQ_FETCH: strobe.takeZero = 1'b1;
      SEQ_MAIN:  strobe.takeMain = 1'b1;
      SEQ_MEM:   strobe.takeMem  = 1'b1;
      default:   strobe.takeNext = 1'b1;
    endcase
  end

endmodule

// File: rtl/useq_datapath.sv
module useq_datapath
  import useq_pkg::*;
#(
  parameter int AW = UA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  seqStrobe_t    strobe,
  input  logic [AW-1:0] mainTgt,
  input  logic [AW-1:0] memTgt,
  output logic [AW-1:0] curAddr
);

  localparam int NSRC = 4;

  logic [AW-1:0]   srcVal [NSRC];
  logic [AW-1:0]   gated  [NSRC];
  logic [NSRC-1:0] pick;
  logic [AW-1:0]   nextAddr;

  assign pick      = {strobe.takeNext, strobe.takeMem, strobe.takeMain, strobe.takeZero};
  assign srcVal[0] = '0;
  assign srcVal[1] = mainTgt;
  assign srcVal[2] = memTgt;
  assign srcVal[3] = curAddr + AW'(1);

  // AND-OR select over one-hot strobes.
  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    assign gated[i] = srcVal[i] & {AW{pick[i]}};
  end

  always_comb begin
    nextAddr = '0;
    for (int i = 0; i < NSRC; i++) nextAddr = nextAddr | gated[i];
  end

  always_ff @(posedge clk) begin
    if (rst) curAddr <= '0;
    else     curAddr <= nextAddr;
  end

endmodule

// File: rtl/micro_sequencer.sv
module micro_sequencer
  import useq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic [1:0]      seqSel,
  output logic [UA_W-1:0] uAddr
);

  seqStrobe_t      strobe;
  logic [UA_W-1:0] mainTgt;
  logic [UA_W-1:0] memTgt;

  useq_ctrl ctrl_i (
    .seqSel (seqSel),
    .strobe (strobe)
  );

  useq_dispatch #(.AW(UA_W)) disp_i (
    .opcode  (opcode),
    .mainTgt (mainTgt),
    .memTgt  (memTgt)
  );

  useq_datapath #(.AW(UA_W)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .mainTgt (mainTgt),
    .memTgt  (memTgt),
    .curAddr (uAddr)
  );

endmodule

// File: rtl/useq_checker.sv
module useq_checker
  import useq_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [OP_W-1:0] opcode,
  input logic [1:0]      seqSel,
  input logic [UA_W-1:0] uAddr
);

  logic known;
  logic isMem;
  assign isMem = (opcode == OPC_LOAD) || (opcode == OPC_STORE);
  assign known = isMem || (opcode == OPC_REG) || (opcode == OPC_JUMP) ||
                 (opcode == OPC_BREQ) || (opcode == OPC_ORIMM);

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> uAddr == '0);

  assert_fetch_zero_R2: assert property (@(posedge clk) disable iff (rst)
    seqSel == SEQ_FETCH |=> uAddr == '0);

  assert_step_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    seqSel == SEQ_NEXT |=> uAddr == UA_W'($past(uAddr) + 1'b1));

  assert_shared_calc_R5: assert property (@(posedge clk) disable iff (rst)
    (seqSel == SEQ_MAIN && isMem) |=> uAddr == UA_W'(ST_ADDRCALC));

  assert_main_trap_R6: assert property (@(posedge clk) disable iff (rst)
    (seqSel == SEQ_MAIN && !known) |=> uAddr == UA_W'(ST_ILLEGAL));

  assert_load_split_R7: assert property (@(posedge clk) disable iff (rst)
    (seqSel == SEQ_MEM && opcode == OPC_LOAD) |=> uAddr == UA_W'(ST_LOADMEM));

  assert_mem_trap_R8: assert property (@(posedge clk) disable iff (rst)
    (seqSel == SEQ_MEM && !isMem) |=> uAddr == UA_W'(ST_ILLEGAL));

endmodule

bind micro_sequencer useq_checker chk_i (
  .clk    (clk),
  .rst    (rst),
  .opcode (opcode),
  .seqSel (seqSel),
  .uAddr  (uAddr)
);

// File: tb/micro_sequencer_tb.sv
module micro_sequencer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [1:0] seqSel = 2'b00;
  logic [3:0] uAddr;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  micro_sequencer dut_i (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .seqSel (seqSel),
    .uAddr  (uAddr)
  );

  function automatic int expNext(int start, int sel, int op);
    case (sel)
      0: return 0;
      3: return (start + 1) % 16;
      1: case (op)
           6'b000000: return 6;
           6'b000010: return 9;
           6'b000100: return 8;
           6'b001011: return 10;
           6'b100011, 6'b101011: return 2;
           default: return 12;
         endcase
      default: case (op)
           6'b100011: return 3;
           6'b101011: return 5;
           default: return 12;
         endcase
    endcase
  endfunction

  function automatic string reqTag(int sel, int op);
    case (sel)
      0: return "R2 R9";
      3: return "R3 R9";
      1: begin
        if (op == 6'b100011 || op == 6'b101011) return "R5";
        if (op == 0 || op == 2 || op == 4 || op == 11) return "R4";
        return "R6";
      end
      default: begin
        if (op == 6'b100011 || op == 6'b101011) return "R7";
        return "R8";
      end
    endcase
  endfunction

  task automatic checkVal(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: uAddr=%0d expected=%0d", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected=<200000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int start = 0; start < 16; start++) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int op = 0; op < 64; op++) begin
          // Reset, then check R1 on the reset value.
          @(negedge clk);
          rst = 1'b1;
          seqSel = 2'(op & 3);
          opcode = 6'(63 - op);
          @(negedge clk);
          checkVal("R1", int'(uAddr), 0);
          rst = 1'b0;
          seqSel = 2'b11;
          // Walk to the start address by stepping.
          for (int k = 0; k < start; k++) @(negedge clk);
          seqSel = 2'(sel);
          opcode = 6'(op);
          @(negedge clk);
          checkVal(reqTag(sel, op), int'(uAddr), expNext(start, sel, op));
        end
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule